// File: doc/BRIEF.md
# Debug Hart Reset Status Tracker

This block is one register slice of a debug module. It holds three flags for every attached hart: halted, resume-acknowledged and have-reset. A debugger reaches it through a small register port with a 7-bit address, 32-bit write data and a strobe. Writing the control register chooses the hart the debugger is looking at. The same write can raise a request to reset the rest of the system, or acknowledge that the selected hart has been reset. Reading the status register returns the flags of the chosen hart.

Harts report their own resets on a pulse input that carries a hart index. The have-reset flag is sticky. A hart reset sets it, and it stays set until the debugger acknowledges it. A hart reset also drops that hart's halted flag. The halt and resume-acknowledge inputs are plain per-hart set strobes. The debug-module reset clears every flag.

Top module: `hart_reset_tracker`

## Requirements
- R1: A pulse on `hartResetPulse` with an index below NUM_HARTS sets that hart's have-reset flag and clears its halted flag at the same clock edge. This holds even when `haltSet` for that hart is high in the same cycle.
- R2: A write to address 0x10 with bit 28 set clears the have-reset flag of the hart named by the hart-select field of that same write. No other hart's flag changes.
- R3: When a reset pulse and an acknowledge write name the same hart in the same cycle, the reset wins and the have-reset flag ends up set.
- R4: A read of address 0x11 returns the status word. Bit 22 is the IMPEBREAK parameter. Bits 19 and 18 both carry the have-reset flag of the selected hart. Bits 9 and 8 carry halted. Bits 17 and 16 carry resume-acknowledged. Bits 11 and 10 are high when the hart exists and is not halted. Bits 13 and 12 read 0. All other bits read 0.
- R5: The hart-select field is bits [16+HARTSELLEN-1:16] of a write to 0x10. Write bits above that field have no effect. A read of 0x10 returns the held hart-select in the same position, with the reset request at bit 1 and zeros elsewhere.
- R6: Bit 1 of every write to 0x10 is latched, and the latched value drives `ndmResetReq` from the next edge onward.
- R7: When the selected index is at or above NUM_HARTS, a status read returns bits 15 and 14 set and bit 22 as IMPEBREAK, with every other bit 0. Reset pulses with such an index change no flag.
- R8: A high bit of `haltSet` sets that hart's halted flag. A high bit of `resumeAckSet` sets that hart's resume-acknowledged flag. Both flags stay set until reset.
- R9: Asserting `rstN` low clears every flag, the hart select, the reset request and the read data.
- R10: Read data is registered. It appears one cycle after a read strobe and holds until the next read. A read of any address other than 0x10 or 0x11 returns 0. A read reflects the state before any update made at the same edge.
- R11: The have-reset flags change only through R1, R2 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low debug-module reset, asynchronous |
| regReq | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read, when regReq is high |
| regAddr | input | 7 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| hartResetPulse | input | 1 | A hart reports that it was reset |
| hartResetIdx | input | HARTSELLEN | Index of the hart that was reset |
| haltSet | input | NUM_HARTS | Per-hart halted set strobes |
| resumeAckSet | input | NUM_HARTS | Per-hart resume-acknowledged set strobes |
| ndmResetReq | output | 1 | Latched system reset request |

## Verification
The hardest case to reach from the ports is a hart reset pulse that lands in the same cycle as an acknowledge write naming the same hart. To get there, the hart-select of the write must match the pulse index, the acknowledge bit must be set, and the strobe must arrive on that exact cycle. The bench forces this case directly for one hart. In its random phase it also draws the pulse index from the same small range as the write's hart-select, and sometimes copies one into the other. A reset that coincides with a halt strobe, and hart indices past NUM_HARTS, are mixed in the same way.

// File: rtl/hart_reset_pkg.sv
package hart_reset_pkg;

  // register addresses
  localparam logic [6:0] ADDR_CTRL = 7'h10;
  localparam logic [6:0] ADDR_STAT = 7'h11;

  // control word field positions
  localparam int CTRL_NDM_BIT = 1;
  localparam int CTRL_SEL_LSB = 16;
  localparam int CTRL_ACK_BIT = 28;

  // status word field positions
  localparam int ST_ANY_HALT  = 8;
  localparam int ST_ALL_HALT  = 9;
  localparam int ST_ANY_RUN   = 10;
  localparam int ST_ALL_RUN   = 11;
  localparam int ST_ANY_UNAV  = 12;
  localparam int ST_ALL_UNAV  = 13;
  localparam int ST_ANY_NONEX = 14;
  localparam int ST_ALL_NONEX = 15;
  localparam int ST_ANY_RACK  = 16;
  localparam int ST_ALL_RACK  = 17;
  localparam int ST_ANY_HRST  = 18;
  localparam int ST_ALL_HRST  = 19;
  localparam int ST_IMPEBRK   = 22;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic ackReq;   // acknowledge have-reset of ackIdx
    logic ctrlWr;   // control register written
    logic statRd;   // status register read
    logic ctrlRd;   // control register read
  } ctrlStrobes_t;

  // flags of the selected hart
  typedef struct packed {
    logic exists;
    logic halted;
    logic resumeAck;
    logic haveReset;
  } hartView_t;

endpackage

// File: rtl/hart_reset_flags.sv
module hart_reset_flags
  import hart_reset_pkg::*;
#(
  parameter int NUM_HARTS  = 16,
  parameter int HARTSELLEN = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [HARTSELLEN-1:0] ackIdx,
  input  logic                  hartResetPulse,
  input  logic [HARTSELLEN-1:0] hartResetIdx,
  input  logic [NUM_HARTS-1:0]  haltSet,
  input  logic [NUM_HARTS-1:0]  resumeAckSet,
  output logic [NUM_HARTS-1:0]  haltedVec,
  output logic [NUM_HARTS-1:0]  resumeAckVec,
  output logic [NUM_HARTS-1:0]  haveResetVec
);

  logic unusedStrobes;
  assign unusedStrobes = ^{strobes.ctrlWr, strobes.statRd, strobes.ctrlRd};

  for (genvar g = 0; g < NUM_HARTS; g++) begin : gHart
    localparam logic [HARTSELLEN-1:0] MY_IDX = HARTSELLEN'(g);

    logic rstHit;
    logic ackHit;
    assign rstHit = hartResetPulse && (hartResetIdx == MY_IDX);
    assign ackHit = strobes.ackReq && (ackIdx == MY_IDX);

    // halted: a hart reset wins over a halt strobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        haltedVec[g] <= 1'b0;
      end else if (rstHit) begin
        haltedVec[g] <= 1'b0;
      end else if (haltSet[g]) begin
        haltedVec[g] <= 1'b1;
      end
    end

    // resume-acknowledged: set-only
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resumeAckVec[g] <= 1'b0;
      end else if (resumeAckSet[g]) begin
        resumeAckVec[g] <= 1'b1;
      end
    end

    // have-reset: sticky, the reset beats the acknowledge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        haveResetVec[g] <= 1'b0;
      end else if (rstHit) begin
        haveResetVec[g] <= 1'b1;
      end else if (ackHit) begin
        haveResetVec[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hart_reset_ctrl.sv
module hart_reset_ctrl
  import hart_reset_pkg::*;
#(
  parameter int NUM_HARTS  = 16,
  parameter int HARTSELLEN = 10,
  parameter bit IMPEBREAK  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regReq,
  input  logic                  regWrite,
  input  logic [6:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic [NUM_HARTS-1:0]  haltedVec,
  input  logic [NUM_HARTS-1:0]  resumeAckVec,
  input  logic [NUM_HARTS-1:0]  haveResetVec,
  output ctrlStrobes_t          strobes,
  output logic [HARTSELLEN-1:0] ackIdx,
  output logic                  ndmResetReq
);

  localparam int IDXW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam int PADN = 1 << IDXW;
  localparam logic [31:0] SEL_MASK =
    ((32'd1 << HARTSELLEN) - 32'd1) << CTRL_SEL_LSB;
  localparam logic [31:0] USED_MASK =
    SEL_MASK | (32'd1 << CTRL_NDM_BIT) | (32'd1 << CTRL_ACK_BIT);

  logic                  isCtrl;
  logic                  isStat;
  logic [HARTSELLEN-1:0] wrSel;
  logic [HARTSELLEN-1:0] hartSel;
  logic                  selExists;
  logic [IDXW-1:0]       selLo;
  logic [PADN-1:0]       haltPad;
  logic [PADN-1:0]       rackPad;
  logic [PADN-1:0]       hrstPad;
  hartView_t             view;
  logic [31:0]           statWord;
  logic [31:0]           ctrlWord;
  logic [31:0]           readWord;
  logic                  unusedWdata;

  assign unusedWdata = ^(regWdata & ~USED_MASK);

  // decode
  assign isCtrl = (regAddr == ADDR_CTRL);
  assign isStat = (regAddr == ADDR_STAT);
  assign wrSel  = regWdata[CTRL_SEL_LSB +: HARTSELLEN];

  always_comb begin
    strobes        = '0;
    strobes.ctrlWr = regReq && regWrite && isCtrl;
    strobes.ackReq = regReq && regWrite && isCtrl && regWdata[CTRL_ACK_BIT];
    strobes.statRd = regReq && !regWrite && isStat;
    strobes.ctrlRd = regReq && !regWrite && isCtrl;
  end

  // acknowledge uses the select value of the same write
  assign ackIdx = wrSel;

  // held hart select and reset request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hartSel     <= '0;
      ndmResetReq <= 1'b0;
    end else if (strobes.ctrlWr) begin
      hartSel     <= wrSel;
      ndmResetReq <= regWdata[CTRL_NDM_BIT];
    end
  end

  // selected hart view
  assign selExists = ({{(32-HARTSELLEN){1'b0}}, hartSel} < 32'(NUM_HARTS));
  assign selLo     = hartSel[IDXW-1:0];
  assign haltPad   = PADN'(haltedVec);
  assign rackPad   = PADN'(resumeAckVec);
  assign hrstPad   = PADN'(haveResetVec);

  always_comb begin
    view.exists    = selExists;
    view.halted    = selExists && haltPad[selLo];
    view.resumeAck = selExists && rackPad[selLo];
    view.haveReset = selExists && hrstPad[selLo];
  end

  // status word
  always_comb begin
    statWord               = '0;
    statWord[ST_IMPEBRK]   = IMPEBREAK;
    statWord[ST_ANY_NONEX] = !view.exists;
    statWord[ST_ALL_NONEX] = !view.exists;
    statWord[ST_ANY_UNAV]  = 1'b0;
    statWord[ST_ALL_UNAV]  = 1'b0;
    statWord[ST_ANY_HALT]  = view.halted;
    statWord[ST_ALL_HALT]  = view.halted;
    statWord[ST_ANY_RUN]   = view.exists && !view.halted;
    statWord[ST_ALL_RUN]   = view.exists && !view.halted;
    statWord[ST_ANY_RACK]  = view.resumeAck;
    statWord[ST_ALL_RACK]  = view.resumeAck;
    statWord[ST_ANY_HRST]  = view.haveReset;
    statWord[ST_ALL_HRST]  = view.haveReset;
  end

  // control readback
  always_comb begin
    ctrlWord                                 = '0;
    ctrlWord[CTRL_SEL_LSB +: HARTSELLEN]     = hartSel;
    ctrlWord[CTRL_NDM_BIT]                   = ndmResetReq;
  end

  always_comb begin
    if (strobes.statRd) begin
      readWord = statWord;
    end else if (strobes.ctrlRd) begin
      readWord = ctrlWord;
    end else begin
      readWord = '0;
    end
  end

  // registered read data, held between reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdata <= '0;
    end else if (regReq && !regWrite) begin
      regRdata <= readWord;
    end
  end

endmodule

// File: rtl/hart_reset_tracker.sv
module hart_reset_tracker
  import hart_reset_pkg::*;
#(
  parameter int NUM_HARTS  = 16,
  parameter int HARTSELLEN = 10,
  parameter bit IMPEBREAK  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regReq,
  input  logic                  regWrite,
  input  logic [6:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  input  logic                  hartResetPulse,
  input  logic [HARTSELLEN-1:0] hartResetIdx,
  input  logic [NUM_HARTS-1:0]  haltSet,
  input  logic [NUM_HARTS-1:0]  resumeAckSet,
  output logic                  ndmResetReq
);

  ctrlStrobes_t          strobes;
  logic [HARTSELLEN-1:0] ackIdx;
  logic [NUM_HARTS-1:0]  haltedVec;
  logic [NUM_HARTS-1:0]  resumeAckVec;
  logic [NUM_HARTS-1:0]  haveResetVec;

  hart_reset_ctrl #(
    .NUM_HARTS (NUM_HARTS),
    .HARTSELLEN(HARTSELLEN),
    .IMPEBREAK (IMPEBREAK)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regReq      (regReq),
    .regWrite    (regWrite),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .haltedVec   (haltedVec),
    .resumeAckVec(resumeAckVec),
    .haveResetVec(haveResetVec),
    .strobes     (strobes),
    .ackIdx      (ackIdx),
    .ndmResetReq (ndmResetReq)
  );

  hart_reset_flags #(
    .NUM_HARTS (NUM_HARTS),
    .HARTSELLEN(HARTSELLEN)
  ) u_flags (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .ackIdx        (ackIdx),
    .hartResetPulse(hartResetPulse),
    .hartResetIdx  (hartResetIdx),
    .haltSet       (haltSet),
    .resumeAckSet  (resumeAckSet),
    .haltedVec     (haltedVec),
    .resumeAckVec  (resumeAckVec),
    .haveResetVec  (haveResetVec)
  );

endmodule

// File: rtl/hart_reset_tracker_chk.sv
module hart_reset_tracker_chk
  import hart_reset_pkg::*;
#(
  parameter int NUM_HARTS  = 16,
  parameter int HARTSELLEN = 10,
  parameter bit IMPEBREAK  = 1'b1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regReq,
  input logic                  regWrite,
  input logic [6:0]            regAddr,
  input logic [31:0]           regWdata,
  input logic [31:0]           regRdata,
  input logic                  hartResetPulse,
  input logic [HARTSELLEN-1:0] hartResetIdx,
  input logic                  ndmResetReq,
  input logic [NUM_HARTS-1:0]  haltedVec,
  input logic [NUM_HARTS-1:0]  haveResetVec
);

  localparam int IDXW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
  localparam int PADN = 1 << IDXW;

  logic [PADN-1:0]       hrPad;
  logic [PADN-1:0]       hlPad;
  logic                  ackWr;
  logic                  ctrlWr;
  logic [HARTSELLEN-1:0] wSel;
  logic                  wOk;
  logic                  rOk;

  assign hrPad  = PADN'(haveResetVec);
  assign hlPad  = PADN'(haltedVec);
  assign ctrlWr = regReq && regWrite && (regAddr == ADDR_CTRL);
  assign ackWr  = ctrlWr && regWdata[CTRL_ACK_BIT];
  assign wSel   = regWdata[CTRL_SEL_LSB +: HARTSELLEN];
  assign wOk    = ({{(32-HARTSELLEN){1'b0}}, wSel} < 32'(NUM_HARTS));
  assign rOk    = ({{(32-HARTSELLEN){1'b0}}, hartResetIdx} < 32'(NUM_HARTS));

  AST_RESET_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    hartResetPulse && rOk |=> hrPad[$past(hartResetIdx[IDXW-1:0])]); // R1

  AST_RESET_DROPS_HALT: assert property (@(posedge clk) disable iff (!rstN)
    hartResetPulse && rOk |=> !hlPad[$past(hartResetIdx[IDXW-1:0])]); // R1

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ackWr && wOk && !(hartResetPulse && hartResetIdx == wSel)
    |=> !hrPad[$past(wSel[IDXW-1:0])]); // R2

  AST_RESET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackWr && wOk && hartResetPulse && hartResetIdx == wSel
    |=> hrPad[$past(wSel[IDXW-1:0])]); // R3

  AST_NDM_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> ndmResetReq == $past(regWdata[CTRL_NDM_BIT])); // R6

  AST_NDM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(ndmResetReq)); // R6

  AST_STAT_IMPEBRK: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regWrite && regAddr == ADDR_STAT
    |=> regRdata[ST_IMPEBRK] == IMPEBREAK); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regReq && !regWrite) |=> $stable(regRdata)); // R10

  AST_HRST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !hartResetPulse && !ackWr |=> $stable(haveResetVec)); // R11

endmodule

bind hart_reset_tracker hart_reset_tracker_chk #(
  .NUM_HARTS (NUM_HARTS),
  .HARTSELLEN(HARTSELLEN),
  .IMPEBREAK (IMPEBREAK)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regReq        (regReq),
  .regWrite      (regWrite),
  .regAddr       (regAddr),
  .regWdata      (regWdata),
  .regRdata      (regRdata),
  .hartResetPulse(hartResetPulse),
  .hartResetIdx  (hartResetIdx),
  .ndmResetReq   (ndmResetReq),
  .haltedVec     (haltedVec),
  .haveResetVec  (haveResetVec)
);

// File: tb/hart_reset_tracker_bench.sv
module hart_reset_tracker_bench;

  localparam int N = 16;
  localparam int L = 10;
  localparam logic [6:0] A_CTRL = 7'h10;
  localparam logic [6:0] A_STAT = 7'h11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regReq = 1'b0;
  logic          regWrite = 1'b0;
  logic [6:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic          hartResetPulse = 1'b0;
  logic [L-1:0]  hartResetIdx = '0;
  logic [N-1:0]  haltSet = '0;
  logic [N-1:0]  resumeAckSet = '0;
  logic          ndmResetReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model
  bit        mHalt [N];
  bit        mRack [N];
  bit        mHrst [N];
  int        mSel;
  bit        mNdm;
  logic [31:0] expRd;

  hart_reset_tracker #(.NUM_HARTS(N), .HARTSELLEN(L), .IMPEBREAK(1'b1)) u_hart_reset_tracker (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .hartResetPulse(hartResetPulse), .hartResetIdx(hartResetIdx),
    .haltSet(haltSet), .resumeAckSet(resumeAckSet), .ndmResetReq(ndmResetReq)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] statusOf(int sel);
    logic [31:0] w = 32'h0040_0000;
    if (sel >= N) begin
      w[15] = 1'b1; w[14] = 1'b1;
    end else begin
      w[9] = mHalt[sel];  w[8] = mHalt[sel];
      w[11] = !mHalt[sel]; w[10] = !mHalt[sel];
      w[17] = mRack[sel]; w[16] = mRack[sel];
      w[19] = mHrst[sel]; w[18] = mHrst[sel];
    end
    return w;
  endfunction

  function automatic logic [31:0] ctrlOf();
    logic [31:0] w = '0;
    w[16 +: L] = L'(mSel);
    w[1] = mNdm;
    return w;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < N; i++) begin
      mHalt[i] = 0; mRack[i] = 0; mHrst[i] = 0;
    end
    mSel = 0; mNdm = 0; expRd = '0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus, with the model stepped alongside
  task automatic doCycle(string req, bit rq, bit wr, logic [6:0] ad, logic [31:0] wd,
                         bit pl, logic [L-1:0] pi, logic [N-1:0] hs, logic [N-1:0] ra);
    int wsel;
    regReq = rq; regWrite = wr; regAddr = ad; regWdata = wd;
    hartResetPulse = pl; hartResetIdx = pi; haltSet = hs; resumeAckSet = ra;
    if (rq && !wr)
      expRd = (ad == A_STAT) ? statusOf(mSel) : (ad == A_CTRL) ? ctrlOf() : 32'h0;
    wsel = int'(wd[16 +: L]);
    for (int i = 0; i < N; i++) begin
      if (hs[i]) mHalt[i] = 1;
      if (ra[i]) mRack[i] = 1;
      if (rq && wr && ad == A_CTRL && wd[28] && wsel == i) mHrst[i] = 0;
      if (pl && int'(pi) == i) begin mHrst[i] = 1; mHalt[i] = 0; end
    end
    if (rq && wr && ad == A_CTRL) begin mSel = wsel; mNdm = wd[1]; end
    @(posedge clk); #2;
    check(req, regRdata, expRd);
    check(req, {31'b0, ndmResetReq}, {31'b0, mNdm});
    regReq = 0; hartResetPulse = 0; haltSet = '0; resumeAckSet = '0;
  endtask

  function automatic logic [31:0] ctrlW(int sel, bit ack, bit ndm);
    logic [31:0] w = '0;
    w[16 +: L] = L'(sel); w[28] = ack; w[1] = ndm;
    return w;
  endfunction

  task automatic wrCtrl(string req, int sel, bit ack, bit ndm);
    doCycle(req, 1, 1, A_CTRL, ctrlW(sel, ack, ndm), 0, '0, '0, '0);
  endtask

  task automatic rdStat(string req);
    doCycle(req, 1, 0, A_STAT, 32'h0, 0, '0, '0, '0);
  endtask

  task automatic idle(string req);
    doCycle(req, 0, 0, 7'h0, 32'h0, 0, '0, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20517);
    modelClear();
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset rdata", regRdata, 32'h0);
    check("R9 reset ndm", {31'b0, ndmResetReq}, 32'h0);
    rstN = 1'b1;
    @(posedge clk); #2;

    rdStat("R9 reset status hart 0");
    idle("R10 read data holds");
    // control readback, masking of upper bits, reset request
    doCycle("R5 masked select", 1, 1, A_CTRL, ctrlW(3, 0, 1) | 32'hE400_0000, 0, '0, '0, '0);
    doCycle("R5 ctrl readback", 1, 0, A_CTRL, 32'h0, 0, '0, '0, '0);
    wrCtrl("R6 ndm clear", 3, 0, 0);
    doCycle("R10 other addr reads zero", 1, 0, 7'h12, 32'h0, 0, '0, '0, '0);
    // halt and resume-ack strobes
    doCycle("R8 halt set", 0, 0, 7'h0, 32'h0, 0, '0, 16'h0008, 16'h0008);
    rdStat("R8 halted hart 3");
    // reset beats a same-cycle halt and clears halted
    doCycle("R1 reset with halt", 0, 0, 7'h0, 32'h0, 1, L'(3), 16'h0008, '0);
    rdStat("R1 have-reset set halted clear");
    // read sees state before a same-edge update
    doCycle("R10 read before update", 1, 0, A_STAT, 32'h0, 1, L'(3), 16'h0008, '0);
    rdStat("R10 following read");
    // ack to another hart leaves hart 3 alone
    wrCtrl("R2 ack other hart", 5, 1, 0);
    wrCtrl("R2 reselect", 3, 0, 0);
    rdStat("R2 hart 3 still set");
    idle("R11 idle"); idle("R11 idle");
    rdStat("R11 sticky");
    wrCtrl("R2 ack hart 3", 3, 1, 0);
    rdStat("R2 cleared");
    // same-cycle reset and ack on hart 3
    doCycle("R3 collide", 1, 1, A_CTRL, ctrlW(3, 1, 0), 1, L'(3), '0, '0);
    rdStat("R3 reset wins");
    // nonexistent selection and out-of-range pulses
    doCycle("R7 pulse past range", 0, 0, 7'h0, 32'h0, 1, L'(20), '0, '0);
    wrCtrl("R7 select 20", 20, 0, 0);
    rdStat("R4 R7 nonexistent status");
    wrCtrl("R7 select max", (1 << L) - 1, 0, 0);
    rdStat("R7 nonexistent max");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit rq = ($urandom % 2) == 0;
      bit wr = ($urandom % 2) == 0;
      int pick = $urandom % 8;
      logic [6:0] ad = (pick < 4) ? A_CTRL : (pick < 7) ? A_STAT : 7'(($urandom % 128));
      int sel = $urandom % 20;
      logic [31:0] wd = $urandom;
      bit pl = ($urandom % 3) == 0;
      int pi = (($urandom % 3) == 0) ? sel : int'($urandom % 20);
      logic [N-1:0] hs = (($urandom % 6) == 0) ? N'(1 << ($urandom % N)) : '0;
      logic [N-1:0] ra = (($urandom % 8) == 0) ? N'(1 << ($urandom % N)) : '0;
      wd[16 +: L] = L'(sel);
      doCycle("R1 R2 R3 R4 R8 random", rq, wr, ad, wd, pl, L'(pi), hs, ra);
    end

    // debug-module reset mid-run
    #1 rstN = 1'b0;
    #3;
    modelClear();
    check("R9 async reset rdata", regRdata, 32'h0);
    @(posedge clk); #1 rstN = 1'b1;
    #1;
    for (int h = 0; h < N; h += 5) begin
      wrCtrl("R9 select", h, 0, 0);
      rdStat("R9 flags cleared");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule